// File: doc/BRIEF.md
# Switched-State Flyback Plant Emulator

This block is a synthesizable, time-stepped model of an ideal flyback converter. A digital power controller under test can run in closed loop against it in logic simulation or on a prototyping fabric. The model keeps two signed fixed-point states: the primary magnetizing current and the output capacitor voltage. On every pulse of the step input it advances both states by one explicit forward-Euler increment. The switch command, captured on the same pulse, decides which of two difference-equation sets applies.

All physical constants are folded into integer coefficients with 16 fractional bits, so an update needs only multiplies, shifts and adds. The coefficients are the step divided by the primary inductance, the step divided by the capacitance, the step divided by the turns ratio times the inductance, the reciprocal turns ratio, and the load conductance. The defaults correspond to a 1 µs step, 352.4 µH, 345.4 µF, a turns ratio of 4 and a 10 Ω load. The load is either a current taken from an input port or a resistor drawing current in proportion to the output voltage. A select input chooses between the two. States are 24-bit words with 12 fractional bits. Every product is floored, meaning it is shifted right arithmetically by 16 bits.

Top module: `flyback_emu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `il`, `vout` and `iin` become 0 at that edge.
- R2: At an edge where `step` is low, `il` and `vout` keep their values whatever the other inputs do.
- R3: On a step with the switch closed (`sw_cmd`=1), `il` gains floor(K_L·vin/2^16) and `vout` loses floor(K_C·load/2^16).
- R4: On a step with the switch open (`sw_cmd`=0), `il` loses floor(K_LN·vout/2^16) and `vout` gains floor(K_C·(floor(K_IN·il/2^16) − load)/2^16).
- R5: Both state updates within one step use the values from before that step.
- R6: With `load_is_res`=1 the load is floor(K_G·vout/2^16) and `iload` is ignored. With `load_is_res`=0 the load equals `iload`.
- R7: A state whose update leaves the range of 24-bit signed words is clamped to 8388607 or −8388608 instead of wrapping.
- R8: `il` never goes below 0. A negative result of an update is replaced by 0.
- R9: `iin` equals `il` when the switch command captured at the last step was 1, and is 0 otherwise.
- R10: `sw_cmd` is captured only on step edges. Changing it between steps changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | One-cycle pulse that advances the model by one time step |
| sw_cmd | input | 1 | Switch command, 1 = closed, 0 = open |
| load_is_res | input | 1 | Load select, 1 = resistor, 0 = current source |
| vin | input | 24 | Input voltage, signed, 12 fractional bits |
| iload | input | 24 | Load current in current-source mode, signed, 12 fractional bits |
| iin | output | 24 | Input current, signed, 12 fractional bits |
| il | output | 24 | Primary magnetizing current, signed, 12 fractional bits |
| vout | output | 24 | Output voltage, signed, 12 fractional bits |

## Verification
Every state result is due one clock after the step pulse that produces it. The inputs of a step are driven on a falling edge, they are captured at the following rising edge, and the outputs are compared on the next falling edge. Each comparison therefore sees exactly one register stage between stimulus and result. `iin` follows the registered switch and current with no further delay, so it is checked in that same half cycle. The hold checks drive several idle cycles with changed inputs and compare on each falling edge in between.

// File: rtl/flyback_pkg.sv
package flyback_pkg;

    // state word: signed, 12 fractional bits
    localparam int W  = 24;
    localparam int QF = 12;
    // coefficient fraction bits and coefficient width
    localparam int CF = 16;
    localparam int CW = 18;
    // intermediate width: holds a coefficient product plus a carry
    localparam int EW = W + CW + 2;

    typedef logic signed [W-1:0]  word_t;
    typedef logic signed [EW-1:0] wide_t;

    typedef enum logic {
        SW_OPEN   = 1'b0,
        SW_CLOSED = 1'b1
    } sw_e;

    typedef struct packed {
        word_t il;
        word_t vo;
    } state_t;

    localparam word_t WMAX = {1'b0, {(W-1){1'b1}}};
    localparam word_t WMIN = {1'b1, {(W-1){1'b0}}};

    function automatic wide_t widen(input word_t x);
        return wide_t'(x);
    endfunction

    // coefficient times value, floored by the coefficient fraction
    function automatic wide_t qmul(input int coef, input wide_t x);
        wide_t c;
        c = wide_t'(coef);
        return (c * x) >>> CF;
    endfunction

    function automatic word_t clamp(input wide_t x);
        if (x > widen(WMAX))
            return WMAX;
        else if (x < widen(WMIN))
            return WMIN;
        else
            return x[W-1:0];
    endfunction

endpackage

// File: rtl/flyback_load.sv
module flyback_load
    import flyback_pkg::*;
#(
    parameter int K_G = 6554
) (
    input  word_t vo,
    input  word_t iload_in,
    input  logic  res_mode,
    output wide_t load
);

    wide_t res_load;

    always_comb begin
        res_load = qmul(K_G, widen(vo));
        load     = res_mode ? res_load : widen(iload_in);
    end

endmodule

// File: rtl/flyback_next.sv
module flyback_next
    import flyback_pkg::*;
#(
    parameter int K_L  = 186,
    parameter int K_C  = 190,
    parameter int K_LN = 46,
    parameter int K_IN = 16384
) (
    input  state_t cur,
    input  sw_e    sw,
    input  word_t  vin,
    input  wide_t  load,
    output state_t nxt
);

    wide_t il_w, vo_w;
    wide_t il_sum, vo_sum;
    wide_t sec_cur;
    word_t il_sat;

    always_comb begin
        il_w    = widen(cur.il);
        vo_w    = widen(cur.vo);
        sec_cur = qmul(K_IN, il_w);
        if (sw == SW_CLOSED) begin
            il_sum = il_w + qmul(K_L, widen(vin));
            vo_sum = vo_w - qmul(K_C, load);
        end else begin
            il_sum = il_w - qmul(K_LN, vo_w);
            vo_sum = vo_w + qmul(K_C, sec_cur - load);
        end
        il_sat = clamp(il_sum);
        // secondary diode: magnetizing current cannot reverse
        nxt.il = il_sat[W-1] ? '0 : il_sat;
        nxt.vo = clamp(vo_sum);
    end

endmodule

// File: rtl/flyback_state.sv
module flyback_state
    import flyback_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    input  state_t nxt,
    input  sw_e    sw_in,
    output state_t cur,
    output sw_e    sw_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            sw_q <= SW_OPEN;
        end else if (step) begin
            cur  <= nxt;
            sw_q <= sw_in;
        end
    end

    // R2
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(cur.il) && $stable(cur.vo)));

    // R8
    il_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> !cur.il[W-1]);

    // R10
    sw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(sw_q));

endmodule

// File: rtl/flyback_emu.sv
module flyback_emu
    import flyback_pkg::*;
#(
    parameter int K_L  = 186,
    parameter int K_C  = 190,
    parameter int K_LN = 46,
    parameter int K_IN = 16384,
    parameter int K_G  = 6554
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    input  logic                sw_cmd,
    input  logic                load_is_res,
    input  logic signed [W-1:0] vin,
    input  logic signed [W-1:0] iload,
    output logic signed [W-1:0] iin,
    output logic signed [W-1:0] il,
    output logic signed [W-1:0] vout
);

    state_t cur, nxt;
    sw_e    sw_in, sw_q;
    wide_t  load;

    assign sw_in = sw_e'(sw_cmd);

    flyback_load #(.K_G(K_G)) u_load (
        .vo       (cur.vo),
        .iload_in (iload),
        .res_mode (load_is_res),
        .load     (load)
    );

    flyback_next #(.K_L(K_L), .K_C(K_C), .K_LN(K_LN), .K_IN(K_IN)) u_next (
        .cur  (cur),
        .sw   (sw_in),
        .vin  (vin),
        .load (load),
        .nxt  (nxt)
    );

    flyback_state u_state (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .nxt   (nxt),
        .sw_in (sw_in),
        .cur   (cur),
        .sw_q  (sw_q)
    );

    assign il   = cur.il;
    assign vout = cur.vo;
    assign iin  = (sw_q == SW_CLOSED) ? cur.il : '0;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (il == '0 && vout == '0 && iin == '0));

    // R9
    open_no_iin_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !sw_cmd) |=> (iin == '0));

    // R9
    closed_iin_chk: assert property (@(posedge clk) disable iff (rst)
        (step && sw_cmd) |=> (iin == il));

endmodule

// File: tb/flyback_emu_test.sv
module flyback_emu_test;

    localparam int  W    = 24;
    localparam int  CF   = 16;
    localparam longint KL = 186, KC = 190, KLN = 46, KIN = 16384, KG = 6554;
    localparam longint VMAX = 8388607;
    localparam longint VMIN = -8388608;

    logic clk = 0;
    logic rst = 1;
    logic step = 0;
    logic sw_cmd = 0;
    logic load_is_res = 0;
    logic signed [W-1:0] vin = '0;
    logic signed [W-1:0] iload = '0;
    logic signed [W-1:0] iin, il, vout;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    longint m_il = 0, m_vo = 0;
    bit     m_sw = 0;

    always #2 clk = ~clk;

    flyback_emu uut (
        .clk(clk), .rst(rst), .step(step), .sw_cmd(sw_cmd),
        .load_is_res(load_is_res), .vin(vin), .iload(iload),
        .iin(iin), .il(il), .vout(vout)
    );

    function automatic longint fl(input longint p);
        return p >>> CF;
    endfunction

    function automatic longint sat(input longint x);
        if (x > VMAX) return VMAX;
        if (x < VMIN) return VMIN;
        return x;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        longint d;
        checks++;
        d = act - exp;
        if (d > 1 || d < -1) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " il"}, longint'(il), m_il);
        chk({tag, " vout"}, longint'(vout), m_vo);
        chk({"R9 iin"}, longint'(iin), m_sw ? m_il : 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        step = 0;
        @(negedge clk);
        rst = 0;
        m_il = 0; m_vo = 0; m_sw = 0;
        chk("R1 il", longint'(il), 0);
        chk("R1 vout", longint'(vout), 0);
        chk("R1 iin", longint'(iin), 0);
    endtask

    task automatic do_step(input bit sw, input bit res, input longint v, input longint ld);
        longint load, n_il, n_vo;
        @(negedge clk);
        sw_cmd = sw;
        load_is_res = res;
        vin = v[W-1:0];
        iload = ld[W-1:0];
        step = 1;
        load = res ? fl(KG * m_vo) : ld;
        if (sw) begin
            n_il = sat(m_il + fl(KL * v));
            n_vo = sat(m_vo - fl(KC * load));
        end else begin
            n_il = sat(m_il - fl(KLN * m_vo));
            n_vo = sat(m_vo + fl(KC * (fl(KIN * m_il) - load)));
        end
        if (n_il < 0) n_il = 0;
        m_il = n_il; m_vo = n_vo; m_sw = sw;
        @(negedge clk);
        step = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();

        // sweep over switch patterns, load modes and input levels (R3 R4 R5 R6)
        for (int i = 0; i < 96; i++) begin
            bit sw, res;
            sw  = (i % 3) != 0;
            res = ((i / 24) % 2) == 1;
            do_step(sw, res, 40960 + i * 3000, i * 1500 - 20000);
            check_all(res ? "R6" : (sw ? "R3 R5" : "R4 R5"));
        end

        // R2 R10: no step, inputs wiggle, nothing moves
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            sw_cmd = ~sw_cmd;
            vin = vin + 24'sd5000;
            iload = iload - 24'sd700;
            load_is_res = ~load_is_res;
            @(negedge clk);
            chk("R2 il hold", longint'(il), m_il);
            chk("R2 vout hold", longint'(vout), m_vo);
            chk("R10 iin hold", longint'(iin), m_sw ? m_il : 0);
        end

        // R8: build up output voltage, then open with no current
        do_reset();
        for (int i = 0; i < 8; i++) begin
            do_step(1'b1, 1'b0, 0, -800000);
            check_all("R3");
        end
        for (int i = 0; i < 4; i++) begin
            do_step(1'b0, 1'b0, 0, 0);
            check_all("R8");
            chk("R8 floor", longint'(il), 0);
        end
        do_step(1'b1, 1'b0, -300000, 0);
        chk("R8 negative vin floor", longint'(il), 0);

        // R7: drive both states into the rails
        do_reset();
        for (int i = 0; i < 400; i++) begin
            do_step(1'b1, 1'b0, VMAX, VMAX);
            check_all("R7");
        end
        chk("R7 il at max", longint'(il), VMAX);
        chk("R7 vout at min", longint'(vout), VMIN);

        // R6: resistor mode ignores the iload port
        do_reset();
        for (int i = 0; i < 6; i++) begin
            do_step(1'b1, 1'b0, 0, -600000);
        end
        for (int i = 0; i < 6; i++) begin
            do_step(1'b0, 1'b1, 0, (i % 2) ? VMAX : VMIN);
            check_all("R6 ignore");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule